// File: doc/BRIEF.md
# I2C Write Master with Sticky Completion and NACK Flags

This block is the transmit half of an I2C bus master. Software programs a clock divider and writes the first data byte into a one-byte holding register. It then writes the 7-bit slave address, which starts a transaction. The block sends START, the address with the write direction bit, and the data bytes, most significant bit first. It checks the slave's acknowledge after every byte and ends with STOP. Each byte passes from the holding register into an internal shift register. While a transaction is open and the holding register is empty, the block raises a request so a DMA engine can write the next byte directly.

Completion and failure are reported through separate flags. The completion flag is a sticky level that only a fresh write into the holding register removes. The NACK flag is a separate bit that clears when the status register is read. A DMA refill that lands just after a NACK therefore cannot erase the evidence of that NACK. A write-one-to-set enable register and a write-one-to-clear disable register build an interrupt mask. The interrupt output is the OR of the masked status bits.

Register offsets on the 3-bit register address:

| Offset | Access | Content |
|---|---|---|
| 0 | W | bits 6:0 slave address; a write starts a transaction |
| 1 | W | transmit holding register |
| 2 | R | status: bit 0 done, bit 1 holding register ready, bit 2 NACK |
| 3 | W | interrupt enable, write one to set the mask bit |
| 4 | W | interrupt disable, write one to clear the mask bit |
| 5 | R | interrupt mask, same bit positions as the status register |
| 6 | R/W | clock divider |

Top module: `i2c_write_master`

## Requirements
- R1: The done flag (status bit 0) sets only after the STOP condition has finished on the bus and only if the holding register is then empty. The one exception is a NACK, where it sets at once.
- R2: Once set, the done flag stays set until a write into the holding register. That write clears it, whether it comes from offset 1 or from the DMA port.
- R3: When the slave answers any byte with NACK (SDA high during the acknowledge clock), the block sets both the done flag and the NACK flag (status bit 2).
- R4: A read of the status register (offset 2) returns the current NACK flag, and the flag then clears. A second read returns 0.
- R5: While a transaction is open and the holding register is empty, dmaReq is high. A dmaWr pulse loads dmaData into the holding register.
- R6: A write to offset 3 sets the mask bits given as ones, and a write to offset 4 clears them. Offset 5 reads the mask back. irq is the OR of status AND mask, so enabling a flag that is already set raises irq on the next cycle.
- R7: After a NACK the block sends STOP, discards any byte in the holding register (ready bit becomes 1), and keeps dmaReq low until a new write to offset 0.
- R8: A transaction on the bus is START, then the address byte {addr[6:0], 0}, then each data byte MSB first, each byte followed by one acknowledge clock, then STOP. SDA changes while SCL is high only to form START and STOP.
- R9: The divider (offset 6, read back at the same offset) sets an SCL period of 4*(div+1) clock cycles.
- R10: The ready bit (status bit 1) is 0 while the holding register is full. It returns to 1 in the cycle the byte moves into the shift register.
- R11: If the holding register is empty when an acknowledged byte finishes, the block issues STOP by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (status read clears NACK) |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regAddr |
| dmaWr | input | 1 | DMA write into the holding register |
| dmaData | input | 8 | DMA write data |
| dmaReq | output | 1 | Holding register can take a byte from DMA |
| irq | output | 1 | OR of enabled status flags |
| sclOut | output | 1 | SCL level, 1 = released |
| sdaOut | output | 1 | SDA drive, 1 = released |
| sdaIn | input | 1 | Sampled SDA bus level |

## Verification
The bench builds the block with a reset divider of 3, reads that value back, and then runs the sweep with divider values 1 and 2. This gives bit times of 8 and 12 cycles and keeps every transaction to a few hundred cycles. At that size the bench can try every data length from 0 to 3 bytes. For each length it tries a NACK on every byte position, plus a transaction with no NACK at all. A NACK on the address byte, on a middle byte and on the last byte each meet the DMA refill at a different moment. A bus-level slave model collects the bytes and the SCL period, and the bench compares them with values it works out from the requirements.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int SLV_AW = 7;
  localparam int STAT_W = 3;
  localparam int STAT_DONE = 0;
  localparam int STAT_READY = 1;
  localparam int STAT_NACK = 2;
  localparam logic [2:0] BIT_LAST = 3'd7;

  localparam logic [2:0] RA_START = 3'd0;
  localparam logic [2:0] RA_TX = 3'd1;
  localparam logic [2:0] RA_STATUS = 3'd2;
  localparam logic [2:0] RA_IEN = 3'd3;
  localparam logic [2:0] RA_IDIS = 3'd4;
  localparam logic [2:0] RA_MASK = 3'd5;
  localparam logic [2:0] RA_DIV = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_ACK,
    ST_STOP
  } busState_t;

  typedef struct packed {
    logic loadAddr;
    logic loadHold;
    logic shift;
    logic nackHit;
    logic stopBegin;
    logic stopDone;
  } ctlStrobe_t;
endpackage

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DIV_RESET = 49
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [2:0]          regAddr,
  input  logic [BYTE_W-1:0]   regWdata,
  output logic [BYTE_W-1:0]   regRdata,
  input  logic                dmaWr,
  input  logic [BYTE_W-1:0]   dmaData,
  output logic                dmaReq,
  output logic                irq,
  input  ctlStrobe_t          strobe,
  output logic                tick,
  output logic                startPend,
  output logic                holdFull,
  output logic                shiftMsb,
  output logic [STAT_W-1:0]   statusVec,
  output logic [STAT_W-1:0]   maskVec
);
  logic [DIV_W-1:0]  divVal;
  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] holdReg;
  logic [BYTE_W-1:0] shifter;
  logic [SLV_AW-1:0] slaveAddr;
  logic              active;
  logic              doneFlag;
  logic              nackFlag;
  logic [STAT_W-1:0] maskReg;

  logic wrStart, wrTx, wrIen, wrIdis, wrDiv, rdStatus, holdWr;
  logic [BYTE_W-1:0] holdNext;

  assign wrStart  = regWr && (regAddr == RA_START);
  assign wrTx     = regWr && (regAddr == RA_TX);
  assign wrIen    = regWr && (regAddr == RA_IEN);
  assign wrIdis   = regWr && (regAddr == RA_IDIS);
  assign wrDiv    = regWr && (regAddr == RA_DIV);
  assign rdStatus = regRd && (regAddr == RA_STATUS);
  assign holdWr   = dmaWr || wrTx;
  assign holdNext = dmaWr ? dmaData : regWdata;

  // bit-phase tick generator
  assign tick = (divCnt == divVal);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      divVal <= DIV_W'(DIV_RESET);
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (wrDiv) divVal <= regWdata[DIV_W-1:0];
    end
  end

  // holding register and shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shifter  <= '1;
    end else begin
      if (holdWr) begin
        holdReg  <= holdNext;
        holdFull <= 1'b1;
      end else if (strobe.loadHold || strobe.nackHit) begin
        holdFull <= 1'b0;
      end
      if (strobe.loadAddr)      shifter <= {slaveAddr, 1'b0};
      else if (strobe.loadHold) shifter <= holdReg;
      else if (strobe.shift)    shifter <= {shifter[BYTE_W-2:0], 1'b1};
    end
  end

  // transaction session and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveAddr <= '0;
      startPend <= 1'b0;
      active    <= 1'b0;
      doneFlag  <= 1'b0;
      nackFlag  <= 1'b0;
      maskReg   <= '0;
    end else begin
      if (wrStart) begin
        slaveAddr <= regWdata[SLV_AW-1:0];
        startPend <= 1'b1;
      end else if (strobe.loadAddr) begin
        startPend <= 1'b0;
      end

      if (wrStart) active <= 1'b1;
      else if (strobe.stopBegin || strobe.nackHit) active <= 1'b0;

      if (holdWr) doneFlag <= 1'b0;
      else if (strobe.nackHit || (strobe.stopDone && !holdFull)) doneFlag <= 1'b1;

      if (strobe.nackHit) nackFlag <= 1'b1;
      else if (rdStatus)  nackFlag <= 1'b0;

      if (wrIen)       maskReg <= maskReg | regWdata[STAT_W-1:0];
      else if (wrIdis) maskReg <= maskReg & ~regWdata[STAT_W-1:0];
    end
  end

  always_comb begin
    statusVec = '0;
    statusVec[STAT_DONE]  = doneFlag;
    statusVec[STAT_READY] = !holdFull;
    statusVec[STAT_NACK]  = nackFlag;
  end

  assign maskVec  = maskReg;
  assign shiftMsb = shifter[BYTE_W-1];
  assign dmaReq   = active && !holdFull;
  assign irq      = |(statusVec & maskReg);

  always_comb begin
    case (regAddr)
      RA_STATUS: regRdata = BYTE_W'(statusVec);
      RA_MASK:   regRdata = BYTE_W'(maskReg);
      RA_DIV:    regRdata = BYTE_W'(divVal);
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       startPend,
  input  logic       holdFull,
  input  logic       shiftMsb,
  input  logic       sdaIn,
  output ctlStrobe_t strobe,
  output logic       sclOut,
  output logic       sdaOut,
  output busState_t  busState
);
  busState_t   st;
  logic [1:0]  q;
  logic [2:0]  bitCnt;
  logic        ackNack;

  assign busState = st;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      q       <= '0;
      bitCnt  <= '0;
      ackNack <= 1'b0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          q <= 2'd0;
          if (startPend) st <= ST_START;
        end
        ST_START: begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            st     <= ST_BITS;
            bitCnt <= BIT_LAST;
          end
        end
        ST_BITS: begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            if (bitCnt == 3'd0) st <= ST_ACK;
            else bitCnt <= bitCnt - 3'd1;
          end
        end
        ST_ACK: begin
          q <= q + 2'd1;
          if (q == 2'd2) ackNack <= sdaIn;
          if (q == 2'd3) begin
            if (ackNack || !holdFull) st <= ST_STOP;
            else begin
              st     <= ST_BITS;
              bitCnt <= BIT_LAST;
            end
          end
        end
        ST_STOP: begin
          q <= q + 2'd1;
          if (q == 2'd3) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (tick) begin
      case (st)
        ST_IDLE: strobe.loadAddr = startPend;
        ST_BITS: strobe.shift = (q == 2'd3) && (bitCnt != 3'd0);
        ST_ACK: begin
          if (q == 2'd3) begin
            if (ackNack) begin
              strobe.nackHit   = 1'b1;
              strobe.stopBegin = 1'b1;
            end else if (holdFull) begin
              strobe.loadHold = 1'b1;
            end else begin
              strobe.stopBegin = 1'b1;
            end
          end
        end
        ST_STOP: strobe.stopDone = (q == 2'd3);
        default: ;
      endcase
    end
  end

  // line levels: SCL low in quarters 0-1, high in 2-3
  always_comb begin
    case (st)
      ST_START: begin sclOut = 1'b1; sdaOut = !q[1]; end
      ST_BITS:  begin sclOut = q[1]; sdaOut = shiftMsb; end
      ST_ACK:   begin sclOut = q[1]; sdaOut = 1'b1; end
      ST_STOP:  begin sclOut = q[1]; sdaOut = (q == 2'd3); end
      default:  begin sclOut = 1'b1; sdaOut = 1'b1; end
    endcase
  end
endmodule

// File: rtl/i2c_write_master.sv
module i2c_write_master
  import i2cw_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DIV_RESET = 49
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       dmaWr,
  input  logic [7:0] dmaData,
  output logic       dmaReq,
  output logic       irq,
  output logic       sclOut,
  output logic       sdaOut,
  input  logic       sdaIn
);
  ctlStrobe_t        strobe;
  logic              tick, startPend, holdFull, shiftMsb;
  logic [STAT_W-1:0] statusVec;
  logic [STAT_W-1:0] maskVec;
  busState_t         busState;

  i2cw_datapath #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) dp_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dmaWr(dmaWr), .dmaData(dmaData),
    .dmaReq(dmaReq), .irq(irq), .strobe(strobe), .tick(tick),
    .startPend(startPend), .holdFull(holdFull), .shiftMsb(shiftMsb),
    .statusVec(statusVec), .maskVec(maskVec)
  );

  i2cw_control ctl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .startPend(startPend),
    .holdFull(holdFull), .shiftMsb(shiftMsb), .sdaIn(sdaIn),
    .strobe(strobe), .sclOut(sclOut), .sdaOut(sdaOut), .busState(busState)
  );
endmodule

// File: rtl/i2c_write_master_chk.sv
module i2c_write_master_chk
  import i2cw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic              regRd,
  input logic [2:0]        regAddr,
  input logic [7:0]        regWdata,
  input logic              dmaWr,
  input logic              dmaReq,
  input logic              irq,
  input logic              sclOut,
  input logic              sdaOut,
  input logic [STAT_W-1:0] statusVec,
  input logic [STAT_W-1:0] maskVec,
  input busState_t         busState
);
  logic holdWrite;
  assign holdWrite = dmaWr || (regWr && regAddr == RA_TX);

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[STAT_DONE]) |-> statusVec[STAT_READY] && (busState == ST_IDLE || busState == ST_STOP)); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[STAT_DONE] && !holdWrite |=> statusVec[STAT_DONE]); // R2
  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    holdWrite |=> !statusVec[STAT_DONE]); // R2
  AST_NACK_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[STAT_NACK]) |-> statusVec[STAT_DONE]); // R3
  AST_NACK_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    regRd && regAddr == RA_STATUS && busState != ST_ACK |=> !statusVec[STAT_NACK]); // R4
  AST_DMA_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> statusVec[STAT_READY]); // R5
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    maskVec == '0 |-> !irq); // R6
  AST_IRQ_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regAddr == RA_IEN && regWdata[STAT_DONE] && statusVec[STAT_DONE] && !dmaWr |=> irq); // R6
  AST_NACK_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[STAT_NACK]) |-> !dmaReq && statusVec[STAT_READY]); // R7
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sclOut && $past(sclOut) && (sdaOut != $past(sdaOut)) |-> busState == ST_START || busState == ST_STOP); // R8
endmodule

bind i2c_write_master i2c_write_master_chk chk_i (.*);

// File: tb/i2c_write_master_tb_top.sv
`timescale 1ns/1ps
module i2c_write_master_tb_top;
  import i2cw_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       regWr = 1'b0, regRd = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       dmaWr = 1'b0;
  logic [7:0] dmaData = '0;
  logic       dmaReq, irq, sclOut, sdaOut, sdaIn;
  logic       slaveDrive = 1'b1;

  assign sdaIn = sdaOut & slaveDrive;

  i2c_write_master #(.DIV_W(8), .DIV_RESET(3)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dmaWr(dmaWr), .dmaData(dmaData),
    .dmaReq(dmaReq), .irq(irq), .sclOut(sclOut), .sdaOut(sdaOut), .sdaIn(sdaIn)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model
  int        cyc = 0, bitIdx = 0, rxCnt = 0, startCnt = 0, stopCnt = 0, byteIdx = 0;
  int        slvNackAt = -1, lastRise = -1, sclPeriod = 0;
  logic [7:0] rxBytes [0:15];
  logic [7:0] shiftIn = '0;
  logic       inFrame = 1'b0, prevScl = 1'b1, prevSda = 1'b1;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (prevScl && sclOut && prevSda && !sdaIn) begin
        startCnt++; inFrame = 1'b1; bitIdx = 0; byteIdx = 0; lastRise = -1;
      end else if (prevScl && sclOut && !prevSda && sdaIn) begin
        stopCnt++; inFrame = 1'b0;
      end else if (inFrame && !prevScl && sclOut) begin
        if (lastRise >= 0) sclPeriod = cyc - lastRise;
        lastRise = cyc;
        if (bitIdx < 8) begin shiftIn = {shiftIn[6:0], sdaIn}; bitIdx++; end
        else bitIdx = 9;
      end else if (inFrame && prevScl && !sclOut) begin
        if (bitIdx == 8) begin
          rxBytes[rxCnt] = shiftIn; rxCnt++;
          slaveDrive = (byteIdx == slvNackAt);
          byteIdx++;
        end else if (bitIdx == 9) begin
          slaveDrive = 1'b1; bitIdx = 0;
        end
      end
      prevScl = sclOut;
      prevSda = sdaIn;
    end
  end

  // DMA engine model
  logic [7:0] feedBytes [0:7];
  int feedIdx = 0, feedLeft = 0;
  initial begin
    forever begin
      @(negedge clk);
      dmaWr = 1'b0;
      if (dmaReq && feedLeft > 0) begin
        dmaData = feedBytes[feedIdx]; dmaWr = 1'b1; feedIdx++; feedLeft--;
      end
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic runXfer(input logic [6:0] addr, input int n, input int nk, input int div);
    logic [7:0] rd;
    int expBytes;
    bit nackCase;
    nackCase = (nk <= n);
    rxCnt = 0; startCnt = 0; stopCnt = 0;
    slvNackAt = nackCase ? nk : -1;
    for (int i = 0; i < n; i++) feedBytes[i] = 8'(8'h41 + 16 * n + 5 * i);
    if (n > 0) begin
      writeReg(RA_TX, feedBytes[0]);
      feedIdx = 1; feedLeft = n - 1;
    end else feedLeft = 0;
    writeReg(RA_START, {1'b0, addr});
    if (n > 0) begin
      readReg(RA_STATUS, rd);
      check("R2 done cleared by holding write", 32'(rd[STAT_DONE]), 32'd0);
    end
    while (stopCnt == 0) @(negedge clk);
    repeat (4 * (div + 1) + 4) @(negedge clk);
    expBytes = nackCase ? nk + 1 : n + 1;
    check("R8 one START", 32'(startCnt), 32'd1);
    check("R11 one STOP and byte count", 32'(rxCnt), 32'(expBytes));
    check("R8 address byte", 32'(rxBytes[0]), 32'({addr, 1'b0}));
    for (int i = 1; i < expBytes; i++)
      check("R8 data byte", 32'(rxBytes[i]), 32'(feedBytes[i - 1]));
    check("R9 SCL period", 32'(sclPeriod), 32'(4 * (div + 1)));
    readReg(RA_STATUS, rd);
    check("R1 R3 status after end", 32'(rd), 32'({nackCase, 1'b1, 1'b1}));
    readReg(RA_STATUS, rd);
    check("R4 nack cleared by read", 32'(rd), 32'(3'b011));
    repeat (20) @(negedge clk);
    check("R7 dmaReq low after end", 32'(dmaReq), 32'd0);
    check("R8 lines released", 32'({sclOut, sdaOut}), 32'(2'b11));
    feedLeft = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readReg(RA_STATUS, rd);
    check("R10 reset status", 32'(rd), 32'(3'b010));
    check("R6 reset irq", 32'(irq), 32'd0);
    check("R5 reset dmaReq", 32'(dmaReq), 32'd0);
    check("R8 reset lines", 32'({sclOut, sdaOut}), 32'(2'b11));
    readReg(RA_DIV, rd);
    check("R9 divider reset value", 32'(rd), 32'd3);

    for (int div = 1; div <= 2; div++) begin
      writeReg(RA_DIV, 8'(div));
      readReg(RA_DIV, rd);
      check("R9 divider readback", 32'(rd), 32'(div));
      for (int n = 0; n <= 3; n++)
        for (int nk = 0; nk <= n + 1; nk++)
          runXfer(7'(7'h50 + n * 3 + nk), n, nk, div);
    end

    // sticky done and interrupt mask
    repeat (50) @(negedge clk);
    readReg(RA_STATUS, rd);
    check("R2 done still set", 32'(rd[STAT_DONE]), 32'd1);
    check("R6 irq with empty mask", 32'(irq), 32'd0);
    writeReg(RA_IEN, 8'h01);
    check("R6 irq immediate on enable", 32'(irq), 32'd1);
    readReg(RA_MASK, rd);
    check("R6 mask readback", 32'(rd), 32'h01);
    writeReg(RA_IDIS, 8'h01);
    check("R6 irq after disable", 32'(irq), 32'd0);
    writeReg(RA_IEN, 8'h04);
    check("R6 irq nack enabled but clear", 32'(irq), 32'd0);
    writeReg(RA_IDIS, 8'h04);

    // ready bit and DMA request around a byte move
    writeReg(RA_TX, 8'h5A);
    readReg(RA_STATUS, rd);
    check("R10 ready low while held", 32'(rd), 32'd0);
    writeReg(RA_IEN, 8'h02);
    check("R10 irq off while full", 32'(irq), 32'd0);
    rxCnt = 0; startCnt = 0; stopCnt = 0; slvNackAt = -1; feedLeft = 0;
    writeReg(RA_START, 8'h2C);
    while (!irq) @(negedge clk);
    readReg(RA_STATUS, rd);
    check("R10 ready after move", 32'(rd[STAT_READY]), 32'd1);
    check("R5 dmaReq while open and empty", 32'(dmaReq), 32'd1);
    feedBytes[0] = 8'hC3; feedIdx = 0; feedLeft = 1;
    while (stopCnt == 0) @(negedge clk);
    repeat (12) @(negedge clk);
    check("R5 DMA byte sent", 32'(rxCnt), 32'd3);
    check("R5 DMA byte value", 32'(rxBytes[2]), 32'hC3);
    check("R8 second byte", 32'(rxBytes[1]), 32'h5A);
    writeReg(RA_IDIS, 8'h07);
    readReg(RA_MASK, rd);
    check("R6 mask cleared", 32'(rd), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule